// File: doc/BRIEF.md
# Numeric Coprocessor Control and Status Word Unit

This block keeps the two 16-bit configuration and state words of a floating-point coprocessor. The control word holds one mask bit per exception together with the precision, rounding and infinity-control fields. The status word holds six sticky exception flags, a stack-fault flag, four condition-code bits, a three-bit stack-top pointer, an error-summary bit and a busy bit.

An execution core drives the update strobes. It raises exception flags, which then stay set. It writes the condition codes and the stack-top pointer. The full control word and the full status word can each be loaded, which is how an environment restore reaches the block. A flag-clear command and an init command are also provided. The block never stores the error-summary and busy bits. Both are always computed from the current flags and masks, so a status load or a mask change shows up on the error output as soon as the register update takes place. The precision field is decoded into a significand width and the rounding field into a mode for the arithmetic datapath.

Top module: `ncp_word_regs`

## Requirements
- R1: After reset, and in the cycle after `init_i`, the control word reads 16'h037F and the status word reads 16'h0000.
- R2: Status bit 7 is 1 exactly when some flag bit in status[5:0] is 1 while the mask bit at the same position in control[5:0] is 0. `err_o` equals status bit 7 at all times.
- R3: Status bit 15 always equals status bit 7.
- R4: Exception flags are sticky. A set request ORs `exc_set_i` into status[5:0] and `sf_set_i` into status bit 6. Only a clear (`clr_flags_i`), a status load or init removes them. A clear leaves the condition codes and the stack-top pointer unchanged.
- R5: A status load (`sw_wr_i`) takes bits 14:8 and 6:0 from `sw_i` in the next cycle. The values of `sw_i[15]` and `sw_i[7]` are ignored, and both bits are recomputed from the loaded flags and the current masks.
- R6: `top_wr_i` stores `top_i` into status bits 13:11. `cc_wr_i` stores `cc_i[3]` into bit 14 and `cc_i[2:0]` into bits 10:8.
- R7: A control load keeps bits 12:8 and 5:0 of `cw_i`. Bit 6 always reads 1, and bits 15:13 and 7 always read 0.
- R8: `prec_bits_o` decodes control[9:8] as follows: 00 gives 24, 10 gives 53 and 11 gives 64. The reserved code 01 gives 64.
- R9: `rnd_mode_o` carries control[11:10]: 0 is nearest-even, 1 is toward minus infinity, 2 is toward plus infinity and 3 is toward zero.
- R10: Control bit 12 is stored and read back, but it has no effect on `prec_bits_o`, `rnd_mode_o` or `err_o`.
- R11: A control load that changes mask bits updates status bit 7 and `err_o` in the cycle after the load, with no status activity needed.
- R12: When several commands arrive in the same cycle, init wins over everything. A status load wins over clear, set, condition-code and stack-top updates. A clear wins over a set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Load default words |
| clr_flags_i | input | 1 | Clear exception flags and stack-fault flag |
| exc_set_i | input | 6 | Exception flag set requests |
| sf_set_i | input | 1 | Stack-fault flag set request |
| cc_wr_i | input | 1 | Condition-code write strobe |
| cc_i | input | 4 | Condition codes C3..C0 |
| top_wr_i | input | 1 | Stack-top write strobe |
| top_i | input | 3 | New stack-top pointer |
| cw_wr_i | input | 1 | Control word load strobe |
| cw_i | input | 16 | Control word load data |
| sw_wr_i | input | 1 | Status word load strobe |
| sw_i | input | 16 | Status word load data |
| cw_o | output | 16 | Control word |
| sw_o | output | 16 | Status word |
| prec_bits_o | output | 7 | Decoded significand width |
| rnd_mode_o | output | 2 | Decoded rounding mode |
| err_o | output | 1 | Unmasked exception pending |

## Verification
Every command takes effect at the single clock edge that samples it. The stored fields therefore appear on `cw_o` and `sw_o` one cycle after the strobe. The derived error-summary bit, busy bit, `err_o` and the decoded fields are combinational from those registers, so they are due in that same cycle and have no further delay. The bench changes inputs 1 ns after a rising edge, takes one edge, and compares every output 1 ns after that edge against values it computes from the requirements. This covers the full sweep of 64 flag patterns against 64 mask patterns and all control-field codes.

// File: rtl/ncp_word_pkg.sv
package ncp_word_pkg;

    localparam int NUM_EXC = 6;
    localparam int TOP_W   = 3;
    localparam int CC_W    = 4;
    localparam int WORD_W  = 16;
    localparam int PREC_W  = 7;

    localparam logic [WORD_W-1:0] CW_INIT = 16'h037F;
    localparam logic [WORD_W-1:0] SW_INIT = 16'h0000;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_DOWN = 2'd1,
        RND_UP   = 2'd2,
        RND_ZERO = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic                ic;
        rnd_mode_e           rc;
        logic [1:0]          pc;
        logic [NUM_EXC-1:0]  mask;
    } ctrl_t;

    typedef struct packed {
        logic [CC_W-1:0]     cc;
        logic [TOP_W-1:0]    top;
        logic                sf;
        logic [NUM_EXC-1:0]  flags;
    } stat_t;

    function automatic ctrl_t cw_unpack(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.ic   = w[12];
        c.rc   = rnd_mode_e'(w[11:10]);
        c.pc   = w[9:8];
        c.mask = w[NUM_EXC-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cw_pack(input ctrl_t c);
        return {3'b000, c.ic, c.rc, c.pc, 1'b0, 1'b1, c.mask};
    endfunction

    function automatic stat_t sw_unpack(input logic [WORD_W-1:0] w);
        stat_t s;
        s.cc    = {w[14], w[10:8]};
        s.top   = w[13:11];
        s.sf    = w[6];
        s.flags = w[NUM_EXC-1:0];
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] sw_pack(input stat_t s, input logic es);
        return {es, s.cc[3], s.top, s.cc[2:0], es, s.sf, s.flags};
    endfunction

    function automatic logic [PREC_W-1:0] prec_width(input logic [1:0] pc);
        logic [PREC_W-1:0] w;
        case (pc)
            2'b00:   w = PREC_W'(24);
            2'b10:   w = PREC_W'(53);
            default: w = PREC_W'(64);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ncp_ctrl_reg.sv
module ncp_ctrl_reg
    import ncp_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            ctrl_q <= cw_unpack(CW_INIT);
        end else if (wr_i) begin
            ctrl_q <= cw_unpack(wdata_i);
        end
    end

    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ncp_stat_reg.sv
module ncp_stat_reg
    import ncp_word_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               init_i,
    input  logic               ld_i,
    input  logic [WORD_W-1:0]  ld_data_i,
    input  logic               clr_i,
    input  logic [NUM_EXC-1:0] exc_set_i,
    input  logic               sf_set_i,
    input  logic               cc_wr_i,
    input  logic [CC_W-1:0]    cc_i,
    input  logic               top_wr_i,
    input  logic [TOP_W-1:0]   top_i,
    output stat_t              stat_o
);
    stat_t stat_q;
    stat_t stat_d;

    always_comb begin
        stat_d = stat_q;
        if (ld_i) begin
            stat_d = sw_unpack(ld_data_i);
        end else begin
            if (clr_i) begin
                stat_d.flags = '0;
                stat_d.sf    = 1'b0;
            end else begin
                stat_d.flags = stat_q.flags | exc_set_i;
                stat_d.sf    = stat_q.sf | sf_set_i;
            end
            if (cc_wr_i) begin
                stat_d.cc = cc_i;
            end
            if (top_wr_i) begin
                stat_d.top = top_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || init_i) begin
            stat_q <= sw_unpack(SW_INIT);
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/ncp_err_sum.sv
module ncp_err_sum
    import ncp_word_pkg::*;
(
    input  logic [NUM_EXC-1:0] flags_i,
    input  logic [NUM_EXC-1:0] mask_i,
    output logic               es_o
);
    logic [NUM_EXC-1:0] unmasked;

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_exc
        assign unmasked[i] = flags_i[i] & ~mask_i[i];
    end

    assign es_o = |unmasked;
endmodule

// File: rtl/ncp_word_regs.sv
module ncp_word_regs
    import ncp_word_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     init_i,
    input  logic                     clr_flags_i,
    input  logic [NUM_EXC-1:0]       exc_set_i,
    input  logic                     sf_set_i,
    input  logic                     cc_wr_i,
    input  logic [CC_W-1:0]          cc_i,
    input  logic                     top_wr_i,
    input  logic [TOP_W-1:0]         top_i,
    input  logic                     cw_wr_i,
    input  logic [WORD_W-1:0]        cw_i,
    input  logic                     sw_wr_i,
    input  logic [WORD_W-1:0]        sw_i,
    output logic [WORD_W-1:0]        cw_o,
    output logic [WORD_W-1:0]        sw_o,
    output logic [PREC_W-1:0]        prec_bits_o,
    output logic [1:0]               rnd_mode_o,
    output logic                     err_o
);
    ctrl_t ctrl;
    stat_t stat;
    logic  es;

    ncp_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .init_i  (init_i),
        .wr_i    (cw_wr_i),
        .wdata_i (cw_i),
        .ctrl_o  (ctrl)
    );

    ncp_stat_reg i_stat (
        .clk       (clk),
        .rst       (rst),
        .init_i    (init_i),
        .ld_i      (sw_wr_i),
        .ld_data_i (sw_i),
        .clr_i     (clr_flags_i),
        .exc_set_i (exc_set_i),
        .sf_set_i  (sf_set_i),
        .cc_wr_i   (cc_wr_i),
        .cc_i      (cc_i),
        .top_wr_i  (top_wr_i),
        .top_i     (top_i),
        .stat_o    (stat)
    );

    ncp_err_sum i_err (
        .flags_i (stat.flags),
        .mask_i  (ctrl.mask),
        .es_o    (es)
    );

    assign cw_o        = cw_pack(ctrl);
    assign sw_o        = sw_pack(stat, es);
    assign prec_bits_o = prec_width(ctrl.pc);
    assign rnd_mode_o  = ctrl.rc;
    assign err_o       = es;
endmodule

// File: rtl/ncp_word_regs_chk.sv
module ncp_word_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        init_i,
    input logic        clr_flags_i,
    input logic        sw_wr_i,
    input logic [15:0] sw_i,
    input logic        cw_wr_i,
    input logic [15:0] cw_i,
    input logic [15:0] cw_o,
    input logic [15:0] sw_o,
    input logic        err_o
);
    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        sw_o[7] == (|(sw_o[5:0] & ~cw_o[5:0]))); // R2

    AST_ERR_PIN: assert property (@(posedge clk) disable iff (rst)
        err_o == sw_o[7]); // R2

    AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (rst)
        sw_o[15] == sw_o[7]); // R3

    AST_INIT_VALUES: assert property (@(posedge clk) disable iff (rst)
        init_i |=> (cw_o == 16'h037F) && (sw_o == 16'h0000)); // R1

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!init_i && !clr_flags_i && !sw_wr_i)
        |=> ((sw_o[6:0] & $past(sw_o[6:0])) == $past(sw_o[6:0]))); // R4

    AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sw_wr_i && !init_i)
        |=> (sw_o[14:8] == $past(sw_i[14:8])) && (sw_o[6:0] == $past(sw_i[6:0]))); // R5

    AST_CW_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cw_wr_i && !init_i)
        |=> cw_o == (($past(cw_i) & 16'h1F3F) | 16'h0040)); // R7
endmodule

bind ncp_word_regs ncp_word_regs_chk i_chk (.*);

// File: tb/test_ncp_word_regs.sv
module test_ncp_word_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_i = 1'b0;
    logic        clr_flags_i = 1'b0;
    logic [5:0]  exc_set_i = '0;
    logic        sf_set_i = 1'b0;
    logic        cc_wr_i = 1'b0;
    logic [3:0]  cc_i = '0;
    logic        top_wr_i = 1'b0;
    logic [2:0]  top_i = '0;
    logic        cw_wr_i = 1'b0;
    logic [15:0] cw_i = '0;
    logic        sw_wr_i = 1'b0;
    logic [15:0] sw_i = '0;
    logic [15:0] cw_o;
    logic [15:0] sw_o;
    logic [6:0]  prec_bits_o;
    logic [1:0]  rnd_mode_o;
    logic        err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ncp_word_regs i_ncp_word_regs (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        init_i = 0; clr_flags_i = 0; exc_set_i = '0; sf_set_i = 0;
        cc_wr_i = 0; top_wr_i = 0; cw_wr_i = 0; sw_wr_i = 0;
    endtask

    function automatic logic [15:0] exp_sw(input logic [5:0] fl, input logic sf,
                                           input logic [3:0] cc, input logic [2:0] tp,
                                           input logic [5:0] mk);
        logic es;
        es = (fl & ~mk) != 0;
        return {es, cc[3], tp, cc[2:0], es, sf, fl};
    endfunction

    function automatic logic [6:0] exp_prec(input logic [1:0] pc);
        return (pc == 2'b00) ? 7'd24 : (pc == 2'b10) ? 7'd53 : 7'd64;
    endfunction

    task automatic check_sw(input string req, input logic [15:0] e);
        chk(sw_o == e, req, 32'(sw_o), 32'(e));
        chk(err_o == e[7], req, 32'(err_o), 32'(e[7]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(cw_o == 16'h037F, "R1 cw reset", 32'(cw_o), 32'h037F);
        check_sw("R1 sw reset", 16'h0000);
        chk(prec_bits_o == 7'd64, "R8 reset prec", 32'(prec_bits_o), 64);
        chk(rnd_mode_o == 2'd0, "R9 reset rnd", 32'(rnd_mode_o), 0);

        // R7 R8 R9 R10: all codes of bits 12:8, junk in fixed bits
        for (int v = 0; v < 32; v++) begin
            cw_wr_i = 1; cw_i = {3'b101, v[4:0], 1'b1, 1'b0, 6'h3F};
            tick();
            chk(cw_o == {3'b000, v[4:0], 1'b0, 1'b1, 6'h3F}, "R7 cw load", 32'(cw_o),
                32'({3'b000, v[4:0], 1'b0, 1'b1, 6'h3F}));
            chk(prec_bits_o == exp_prec(v[1:0]), "R8 prec decode", 32'(prec_bits_o), 32'(exp_prec(v[1:0])));
            chk(rnd_mode_o == v[3:2], "R9 rnd decode", 32'(rnd_mode_o), 32'(v[3:2]));
            chk(err_o == 1'b0, "R10 ic no err effect", 32'(err_o), 0);
        end

        // R2 R3 R5: every flag pattern against every mask pattern
        for (int m = 0; m < 64; m++) begin
            cw_wr_i = 1; cw_i = {3'b000, 5'b00011, 1'b0, 1'b1, m[5:0]};
            tick();
            for (int f = 0; f < 64; f++) begin
                logic [15:0] d;
                d = {f[0], f[1], f[5:3], f[2], m[0], f[4], ~f[0], f[5], f[5:0]};
                sw_wr_i = 1; sw_i = d;
                tick();
                check_sw("R2 R3 R5 sw load sweep",
                         exp_sw(f[5:0], f[5], {f[1], f[2], m[0], f[4]}, f[5:3], m[5:0]));
            end
        end

        // R11: mask change alone re-evaluates error
        cw_wr_i = 1; cw_i = 16'h037F; tick();
        sw_wr_i = 1; sw_i = 16'h0001; tick();
        check_sw("R11 masked", exp_sw(6'h01, 0, 4'h0, 3'd0, 6'h3F));
        cw_wr_i = 1; cw_i = 16'h037E; tick();
        check_sw("R11 unmask", exp_sw(6'h01, 0, 4'h0, 3'd0, 6'h3E));
        cw_wr_i = 1; cw_i = 16'h037F; tick();
        check_sw("R11 remask", exp_sw(6'h01, 0, 4'h0, 3'd0, 6'h3F));

        // R4 sticky flags, clear keeps cc/top
        init_i = 1; tick();
        chk(cw_o == 16'h037F, "R1 init cw", 32'(cw_o), 32'h037F);
        check_sw("R1 init sw", 16'h0000);
        cc_wr_i = 1; cc_i = 4'hA; top_wr_i = 1; top_i = 3'd5; tick();
        exc_set_i = 6'h01; tick();
        exc_set_i = 6'h04; tick();
        check_sw("R4 or accumulate", exp_sw(6'h05, 0, 4'hA, 3'd5, 6'h3F));
        sf_set_i = 1; tick();
        tick();
        check_sw("R4 hold", exp_sw(6'h05, 1, 4'hA, 3'd5, 6'h3F));
        cw_wr_i = 1; cw_i = 16'h0340; tick();
        check_sw("R4 R2 unmasked flags", exp_sw(6'h05, 1, 4'hA, 3'd5, 6'h00));
        clr_flags_i = 1; tick();
        check_sw("R4 clear", exp_sw(6'h00, 0, 4'hA, 3'd5, 6'h00));

        // R6 cc and top fields
        for (int t = 0; t < 8; t++) begin
            for (int c = 0; c < 16; c++) begin
                cc_wr_i = 1; cc_i = c[3:0]; top_wr_i = 1; top_i = t[2:0];
                tick();
                check_sw("R6 cc top fields", exp_sw(6'h00, 0, c[3:0], t[2:0], 6'h00));
            end
        end

        // R12 priorities
        exc_set_i = 6'h08; clr_flags_i = 1; tick();
        check_sw("R12 clear over set", exp_sw(6'h00, 0, 4'hF, 3'd7, 6'h00));
        sw_wr_i = 1; sw_i = 16'h0802; exc_set_i = 6'h10; cc_wr_i = 1; cc_i = 4'h3;
        top_wr_i = 1; top_i = 3'd2; tick();
        check_sw("R12 load over updates", exp_sw(6'h02, 0, 4'h0, 3'd1, 6'h00));
        init_i = 1; cw_wr_i = 1; cw_i = 16'h0C00; sw_wr_i = 1; sw_i = 16'h00FF; tick();
        chk(cw_o == 16'h037F, "R12 init over cw load", 32'(cw_o), 32'h037F);
        check_sw("R12 init over sw load", 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule